// File: doc/BRIEF.md
# E1 Alarm Indication Signal Detector

This block watches a received E1 bit stream for the alarm indication signal, the "blue alarm", which is a stream that is all ones or nearly so. It splits the enabled bits into back-to-back blocks of a fixed length. For each block it decides whether the block was short of zeros. A block is short of zeros when it holds fewer than a threshold number of zero bits. The alarm is raised after two short blocks in a row. It is dropped after two blocks in a row that each reach the zero threshold.

The line recovery logic feeds it a bit-clock enable and the recovered data bit. The block reports a level-type alarm status and a single-cycle pulse each time that status flips. The status is only re-evaluated at the clock edge that takes in the last bit of a block. Between those edges, nothing on the input changes either output.

Top module: `e1ais_detector`

## Requirements
- R1: A block is exactly PERIOD_BITS (default 512) cycles in which `bit_en` is high. Blocks follow one another with no overlap. Cycles with `bit_en` low are not counted, and `rx_bit` is ignored in those cycles.
- R2: A zero bit is `rx_bit` = 0 while `bit_en` = 1. A block is deficient when it holds fewer than ZERO_MIN (default 3) zero bits. Exactly ZERO_MIN zeros makes the block non-deficient.
- R3: When a block ends deficient and the block just before it was also deficient, `ais_o` is 1 from the clock edge that takes in the block's last bit.
- R4: When a block ends non-deficient and the block just before it was also non-deficient, `ais_o` is 0 from the clock edge that takes in the block's last bit.
- R5: When the two most recent blocks disagree (one deficient, one not), `ais_o` keeps its value. `ais_o` never changes except at a block end.
- R6: `ais_change_o` is high for exactly one cycle, in the first cycle where `ais_o` shows its new value. It is low in every other cycle.
- R7: While `rst` is high, and right after it is released, `ais_o` and `ais_change_o` are 0. The block position restarts at bit zero and the previous-block history is empty. The first block completed after reset therefore cannot change `ais_o` on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | High in cycles that carry a received bit |
| rx_bit | input | 1 | Received data bit, valid when bit_en is high |
| ais_o | output | 1 | Alarm status, registered |
| ais_change_o | output | 1 | One-cycle pulse when ais_o changes, registered |

## Verification
The bench goes after the zero-count boundary: blocks with exactly two zeros and exactly three zeros. A design with the wrong comparison would raise or hold the alarm one zero off. It also places zeros on the first and last bit of a block. A block counter that is off by one, or a tally that misses the bit arriving at the block end, would then classify the block wrongly or change the alarm one block late.

Zeros are driven on `rx_bit` during idle cycles (`bit_en` low). A design that counted them would never raise the alarm. Alternating short and healthy blocks show whether mixed pairs hold the state. A design that compares with stale history, or that acts on the first block after reset, would toggle the alarm in those cases.

// File: rtl/e1ais_pkg.sv
package e1ais_pkg;

  // Outcome of a block-end evaluation.
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_SET   = 2'd1,
    EV_CLEAR = 2'd2
  } ais_event_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/e1ais_bit_timer.sv
module e1ais_bit_timer #(
  parameter int PERIOD_BITS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  output logic block_end
);
  localparam int PW = (PERIOD_BITS < 2) ? 1 : $clog2(PERIOD_BITS);
  localparam logic [PW-1:0] LAST = PW'(PERIOD_BITS - 1);

  logic [PW-1:0] pos_q;

  assign block_end = bit_en && (pos_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (bit_en) begin
      if (pos_q == LAST) pos_q <= '0;
      else               pos_q <= pos_q + PW'(1);
    end
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST); // R1
  AST_POS_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(pos_q)); // R1

endmodule

// File: rtl/e1ais_zero_tally.sv
module e1ais_zero_tally #(
  parameter int ZERO_MIN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic block_end,
  output logic cur_deficient
);
  localparam int CW = e1ais_pkg::cnt_width(ZERO_MIN);
  localparam logic [CW-1:0] LIM = CW'(ZERO_MIN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_incl;

  // Count including the bit arriving in this cycle, saturated at LIM.
  always_comb begin
    cnt_incl = cnt_q;
    if (bit_en && !rx_bit && (cnt_q < LIM)) cnt_incl = cnt_q + CW'(1);
  end

  assign cur_deficient = (cnt_incl < LIM);

  always_ff @(posedge clk) begin
    if (rst || block_end) cnt_q <= '0;
    else                  cnt_q <= cnt_incl;
  end

  AST_ZCNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIM); // R2
  AST_ZCNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/e1ais_alarm_fsm.sv
module e1ais_alarm_fsm (
  input  logic clk,
  input  logic rst,
  input  logic block_end,
  input  logic cur_deficient,
  output logic ais,
  output logic ais_change
);
  import e1ais_pkg::*;

  logic       hist_valid_q;
  logic       prev_def_q;
  logic       ais_q;
  logic       chg_q;
  ais_event_e ev;

  always_comb begin
    ev = EV_NONE;
    if (block_end && hist_valid_q) begin
      if (prev_def_q && cur_deficient && !ais_q)        ev = EV_SET;
      else if (!prev_def_q && !cur_deficient && ais_q)  ev = EV_CLEAR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_valid_q <= 1'b0;
      prev_def_q   <= 1'b0;
      ais_q        <= 1'b0;
      chg_q        <= 1'b0;
    end else begin
      chg_q <= (ev != EV_NONE);
      if (block_end) begin
        hist_valid_q <= 1'b1;
        prev_def_q   <= cur_deficient;
      end
      case (ev)
        EV_SET:   ais_q <= 1'b1;
        EV_CLEAR: ais_q <= 1'b0;
        default:  ais_q <= ais_q;
      endcase
    end
  end

  assign ais        = ais_q;
  assign ais_change = chg_q;

  AST_SET_AFTER_TWO_SHORT: assert property (@(posedge clk) disable iff (rst)
    (block_end && hist_valid_q && prev_def_q && cur_deficient) |=> ais_q); // R3
  AST_CLEAR_AFTER_TWO_OK: assert property (@(posedge clk) disable iff (rst)
    (block_end && hist_valid_q && !prev_def_q && !cur_deficient) |=> !ais_q); // R4
  AST_MIXED_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (block_end && (prev_def_q != cur_deficient)) |=> $stable(ais_q)); // R5
  AST_QUIET_BETWEEN_ENDS: assert property (@(posedge clk) disable iff (rst)
    !block_end |=> $stable(ais_q)); // R5
  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (ais_q != $past(ais_q)) |-> chg_q); // R6
  AST_PULSE_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    chg_q |-> (ais_q != $past(ais_q))); // R6
  AST_FIRST_BLOCK_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (block_end && !hist_valid_q) |=> !chg_q); // R7

endmodule

// File: rtl/e1ais_detector.sv
module e1ais_detector #(
  parameter int PERIOD_BITS = 512,
  parameter int ZERO_MIN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic rx_bit,
  output logic ais_o,
  output logic ais_change_o
);
  logic block_end;
  logic cur_deficient;

  e1ais_bit_timer #(.PERIOD_BITS(PERIOD_BITS)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .block_end (block_end)
  );

  e1ais_zero_tally #(.ZERO_MIN(ZERO_MIN)) tally_i (
    .clk           (clk),
    .rst           (rst),
    .bit_en        (bit_en),
    .rx_bit        (rx_bit),
    .block_end     (block_end),
    .cur_deficient (cur_deficient)
  );

  e1ais_alarm_fsm fsm_i (
    .clk           (clk),
    .rst           (rst),
    .block_end     (block_end),
    .cur_deficient (cur_deficient),
    .ais           (ais_o),
    .ais_change    (ais_change_o)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!ais_o && !ais_change_o)); // R7

endmodule

// File: tb/e1ais_detector_tb_top.sv
module e1ais_detector_tb_top;
  localparam int NB = 512;
  localparam int ZM = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic rx_bit = 1'b1;
  logic ais_o, ais_change_o;

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  // Reference model state
  int    m_pos = 0;
  int    m_z = 0;
  bit    m_prev = 0;
  bit    m_valid = 0;
  bit    m_ais = 0;
  bit    m_chg = 0;
  string m_tag = "R7";

  bit pat [NB];

  always #2 clk = ~clk;

  e1ais_detector #(.PERIOD_BITS(NB), .ZERO_MIN(ZM)) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .ais_o(ais_o), .ais_change_o(ais_change_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic bit block_deficient(input int zeros);
    return zeros < ZM;   // R2
  endfunction

  task automatic model_step(input bit en, input bit b);
    m_chg = 0;
    if (en) begin
      if (!b) m_z++;
      if (m_pos == NB - 1) begin
        bit d;
        d = block_deficient(m_z);
        m_tag = "R5";
        if (!m_valid) m_tag = "R7";
        else if (m_prev && d) begin
          m_tag = "R3";
          if (!m_ais) begin m_ais = 1; m_chg = 1; end
        end else if (!m_prev && !d) begin
          m_tag = "R4";
          if (m_ais) begin m_ais = 0; m_chg = 1; end
        end
        m_prev = d; m_valid = 1; m_z = 0; m_pos = 0;
      end else m_pos++;
    end
  endtask

  task automatic step(input bit en, input bit b);
    @(negedge clk);
    chk(m_tag, "ais_o", ais_o, m_ais);
    chk("R6", "ais_change_o", ais_change_o, m_chg);
    bit_en = en;
    rx_bit = b;
    @(posedge clk);
    model_step(en, b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; bit_en = 0; rx_bit = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_pos = 0; m_z = 0; m_prev = 0; m_valid = 0; m_ais = 0; m_chg = 0; m_tag = "R7";
    chk("R7", "ais_o after reset", ais_o, 1'b0);
    chk("R7", "ais_change_o after reset", ais_change_o, 1'b0);
  endtask

  // edge=1 places zeros at the last bit, the first bit, then upward.
  task automatic build(input int nz, input bit edge_pos);
    for (int i = 0; i < NB; i++) pat[i] = 1;
    if (edge_pos) begin
      for (int k = 0; k < nz; k++) pat[(k == 0) ? NB - 1 : k - 1] = 0;
    end else begin
      int placed = 0;
      while (placed < nz) begin
        int p = $urandom_range(NB - 1, 0);
        if (pat[p]) begin pat[p] = 0; placed++; end
      end
    end
  endtask

  // idle_pct: chance of idle cycles carrying a zero on rx_bit.
  task automatic run_block(input int nz, input bit edge_pos, input int idle_pct);
    build(nz, edge_pos);
    for (int i = 0; i < NB; i++) begin
      if (idle_pct > 0 && $urandom_range(99, 0) < idle_pct) step(1'b0, 1'b0); // R1
      step(1'b1, pat[i]);
    end
  endtask

  task automatic settle();
    step(1'b0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'h1e1a15));
    do_reset();

    // R7: first block after reset alone cannot raise the alarm
    run_block(0, 1'b0, 0);
    settle();
    chk("R7", "first short block, no history", ais_o, 1'b0);

    // R3 + R2 boundary: second short block with exactly two zeros, at edges
    run_block(2, 1'b1, 0);
    settle();
    chk("R3", "set after two short blocks (2 zeros)", ais_o, 1'b1);

    // R5: mixed pairs hold the alarm
    run_block(3, 1'b1, 0);
    settle();
    chk("R5", "short then ok holds set", ais_o, 1'b1);
    run_block(1, 1'b0, 0);
    settle();
    chk("R5", "ok then short holds set", ais_o, 1'b1);

    // R4 + R2: exactly three zeros twice clears
    run_block(3, 1'b1, 0);
    run_block(3, 1'b0, 0);
    settle();
    chk("R4", "clear after two blocks with 3 zeros", ais_o, 1'b0);

    // R1: many zeros during idle cycles must be ignored
    run_block(0, 1'b0, 20);
    run_block(1, 1'b0, 20);
    settle();
    chk("R1", "idle zeros ignored, alarm set", ais_o, 1'b1);

    // R7: reset mid-alarm, mid-block
    for (int i = 0; i < 100; i++) step(1'b1, 1'b1);
    do_reset();
    run_block(0, 1'b0, 0);
    settle();
    chk("R7", "history empty after reset", ais_o, 1'b0);

    // Random mix
    for (int n = 0; n < 50; n++) begin
      int sel = $urandom_range(5, 0);
      int nz;
      case (sel)
        0: nz = 0;
        1: nz = 1;
        2: nz = 2;
        3: nz = 3;
        4: nz = 4;
        default: nz = $urandom_range(60, 5);
      endcase
      run_block(nz, $urandom_range(3, 0) == 0, $urandom_range(1, 0) ? 10 : 0);
    end
    settle();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule